// File: doc/BRIEF.md
# Bipolar Transmit Line Encoder (T1/E1)

This block turns system-side transmit data into the two mark signals that drive a bipolar line: `line_pos` requests a positive pulse and `line_neg` requests a negative pulse. It produces one symbol per active edge of the transmit clock. The whole block runs on a free-running master clock. The transmit clock and the data inputs are brought into that domain through a short synchronizer, and an edge detector then turns the chosen transmit-clock edge into a one-cycle symbol strobe.

In single-rail operation one data input is coded. The coding is plain alternate mark inversion, or alternate mark inversion with zero substitution. The substitution is four-zero HDB3 for E1 and eight-zero B8ZS for T1/J1. Coded data passes through a fixed eight-symbol pipeline, so that a substitution can rewrite zeros that have already been accepted.

In dual-rail operation the two rail inputs are mapped straight to line polarity and the coder is bypassed. A watchdog counts master-clock cycles between transmit-clock edges. When that count exceeds a limit, it raises a loss-of-clock condition, which reaches the interrupt output unless the interrupt is masked.

Top module: `tx_line_encoder`

## Requirements
- R1: With `cfg_dual`=0 and `cfg_zsub`=0 (AMI), each 1 bit becomes a mark whose polarity is opposite to the previous mark, and each 0 bit becomes a space. The first mark after reset is positive.
- R2: With `cfg_dual`=0, `cfg_t1`=0 and `cfg_zsub`=1 (HDB3), every fourth consecutive zero completes a substitution. The substitution is B00V when an even number of 1 bits have been sent since the previous substitution (or since reset), and 000V otherwise. A V mark has the same polarity as the mark before it, and a B mark has the opposite polarity.
- R3: With `cfg_dual`=0, `cfg_t1`=1 and `cfg_zsub`=1 (B8ZS), every eighth consecutive zero completes the substitution 000VB0VB, using the same V and B polarity rules as R2.
- R4: In single-rail modes, the symbol for the bit sampled at strobe k appears on the outputs at strobe k+8. Before that, from reset onwards, the outputs carry spaces.
- R5: With `cfg_dual`=1, the rails sampled at a strobe appear on the outputs at that same strobe. Positive rail 1 with negative rail 0 gives a negative mark. Positive rail 0 with negative rail 1 gives a positive mark. Equal rails give a space. `cfg_t1` and `cfg_zsub` have no effect in this mode.
- R6: Data is sampled on rising transmit-clock edges when `cfg_fall_edge`=0 and on falling edges when it is 1. The outputs change only in the master-clock cycle that follows a strobe, which comes three master-clock cycles after the active edge.
- R7: When `cfg_invert`=1, both data inputs are inverted before any other processing.
- R8: `line_pos` and `line_neg` are never 1 at the same time.
- R9: If the transmit clock shows no edge for more than 70 master-clock cycles, a loss condition is set. The next transmit-clock edge clears it. `los_irq` equals the loss condition when `cfg_los_mask`=0 and is 0 when `cfg_los_mask`=1.
- R10: While reset is low, `line_pos`, `line_neg` and `los_irq` are 0 from the following clock edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tclk_in | input | 1 | Transmit clock, asynchronous to `clk` |
| tx_data | input | 1 | Single-rail data, or the positive rail in dual-rail mode |
| tx_neg | input | 1 | Negative rail in dual-rail mode |
| cfg_t1 | input | 1 | 0 selects E1 (HDB3), 1 selects T1/J1 (B8ZS) |
| cfg_dual | input | 1 | 0 selects single-rail coding, 1 selects dual-rail bypass |
| cfg_zsub | input | 1 | 1 enables zero substitution, 0 selects plain AMI |
| cfg_fall_edge | input | 1 | 1 samples on falling edges of the transmit clock |
| cfg_invert | input | 1 | 1 inverts both data inputs |
| cfg_los_mask | input | 1 | 1 masks the loss-of-clock interrupt |
| line_pos | output | 1 | Positive mark request |
| line_neg | output | 1 | Negative mark request |
| los_irq | output | 1 | Loss-of-transmit-clock interrupt |

## Verification
The hardest situation to bring about from the ports is a B8ZS substitution that lands on a known earlier mark polarity. The same applies to an HDB3 run that meets both parities of the mark count, because long zero runs are rare in evenly random data. The stimulus therefore draws bits with a bias toward zero, which produces frequent runs of four and eight zeros after marks of either polarity. It also adds directed all-zero streams, where substitution follows substitution with no data mark in between. Loss of clock is produced by parking the transmit clock for windows just below and well above the limit.

// File: rtl/tle_pkg.sv
// Shared types for the transmit line encoder.
// Assumes: symbols in the coding pipeline are tagged by role, and polarity is
// resolved only when a symbol leaves the pipeline.
package tle_pkg;
    typedef enum logic [1:0] {
        SYM_SPACE = 2'd0,   // no pulse
        SYM_MARK  = 2'd1,   // pulse that alternates with the previous one
        SYM_VIOL  = 2'd2    // pulse that repeats the previous polarity
    } sym_t;

    localparam int RUN_W    = 4;
    localparam int RUN_HDB3 = 4;
    localparam int RUN_B8ZS = 8;
endpackage

// File: rtl/tle_edge_sync.sv
// Brings the transmit clock and both data inputs into the master clock domain
// and turns the selected transmit-clock edge into a one-cycle strobe.
// Assumes: the data is held steady for at least SYNC_STAGES master cycles on
// each side of the active edge, and each transmit-clock phase lasts at least
// two master cycles.
module tle_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tclk_in,
    input  logic din_a,
    input  logic din_b,
    input  logic fall_sel,
    input  logic invert,
    output logic sym_stb,
    output logic any_edge,
    output logic rail_a,
    output logic rail_b
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES:0]   ck_q;
    logic [SYNC_STAGES-1:0] a_q;
    logic [SYNC_STAGES-1:0] b_q;
    logic                   ck_now;
    logic                   ck_old;

    // Shift the clock and the data through matching synchronizer chains.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ck_q <= '0;
            a_q  <= '0;
            b_q  <= '0;
        end else begin
            ck_q <= {ck_q[SYNC_STAGES-1:0], tclk_in};
            a_q  <= {a_q[SYNC_STAGES-2:0], din_a};
            b_q  <= {b_q[SYNC_STAGES-2:0], din_b};
        end
    end

    // Detect edges on the synchronized clock and apply the polarity option.
    always_comb begin
        ck_now   = ck_q[LAST];
        ck_old   = ck_q[SYNC_STAGES];
        any_edge = ck_now ^ ck_old;
        sym_stb  = fall_sel ? (ck_old & ~ck_now) : (ck_now & ~ck_old);
        rail_a   = a_q[LAST] ^ invert;
        rail_b   = b_q[LAST] ^ invert;
    end
endmodule

// File: rtl/tle_zs_encoder.sv
// Single-rail coder: AMI, with optional HDB3 (E1) or B8ZS (T1) zero
// substitution. Bits enter a DEPTH-entry tagged pipeline. A completed zero run
// rewrites the entries it covers, and polarity is assigned at the tail.
// Assumes: DEPTH >= 8 so that a whole B8ZS run is still held in the pipeline.
// The mode inputs are static between resets.
module tle_zs_encoder
    import tle_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stb,
    input  logic bit_in,
    input  logic std_t1,
    input  logic zsub_en,
    output logic mk_pos,
    output logic mk_neg
);
    localparam logic [RUN_W-1:0] HDB3_LEN = RUN_W'(RUN_HDB3);
    localparam logic [RUN_W-1:0] B8ZS_LEN = RUN_W'(RUN_B8ZS);
    localparam logic [RUN_W-1:0] RUN_MAX  = '1;

    sym_t             sr  [DEPTH];
    sym_t             nxt [DEPTH];
    logic [RUN_W-1:0] run_q, run_d;
    logic             par_q, par_d;
    logic             last_pos_q;
    sym_t             head;
    logic             head_pos;

    // Shift in the new bit and apply any substitution completed by it.
    always_comb begin
        nxt[0] = bit_in ? SYM_MARK : SYM_SPACE;
        for (int i = 1; i < DEPTH; i++) begin
            nxt[i] = sr[i-1];
        end
        run_d = run_q;
        par_d = par_q;
        if (bit_in) begin
            run_d = '0;
            par_d = ~par_q;
        end else begin
            run_d = (run_q == RUN_MAX) ? run_q : run_q + 1'b1;
            if (zsub_en && !std_t1 && run_d == HDB3_LEN) begin
                if (!par_q) begin
                    nxt[3] = SYM_MARK;
                end
                nxt[0] = SYM_VIOL;
                run_d  = '0;
                par_d  = 1'b0;
            end else if (zsub_en && std_t1 && run_d == B8ZS_LEN) begin
                nxt[4] = SYM_VIOL;
                nxt[3] = SYM_MARK;
                nxt[1] = SYM_VIOL;
                nxt[0] = SYM_MARK;
                run_d  = '0;
            end
        end
    end

    // Resolve the polarity of the symbol that leaves the pipeline.
    always_comb begin
        head     = sr[DEPTH-1];
        head_pos = (head == SYM_VIOL) ? last_pos_q : ~last_pos_q;
        mk_pos   = (head != SYM_SPACE) &&  head_pos;
        mk_neg   = (head != SYM_SPACE) && !head_pos;
    end

    // Advance the pipeline, the run and parity counts and the polarity on each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                sr[i] <= SYM_SPACE;
            end
            run_q      <= '0;
            par_q      <= 1'b0;
            last_pos_q <= 1'b0;
        end else if (stb) begin
            sr    <= nxt;
            run_q <= run_d;
            par_q <= par_d;
            if (head != SYM_SPACE) begin
                last_pos_q <= head_pos;
            end
        end
    end
endmodule

// File: rtl/tle_clk_watch.sv
// Loss-of-transmit-clock watchdog. It counts master cycles since the last
// transmit-clock edge and flags loss once the count exceeds LIMIT.
// Assumes: any_edge is a one-cycle pulse per synchronized edge.
module tle_clk_watch #(
    parameter int LIMIT = 70
) (
    input  logic clk,
    input  logic rst_n,
    input  logic any_edge,
    input  logic mask,
    output logic irq
);
    localparam int CW = $clog2(LIMIT + 2);
    localparam logic [CW-1:0] SAT = CW'(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] quiet_q;
    logic [CW-1:0] quiet_d;
    logic          lost_q;

    // Next value of the quiet-cycle count, saturating above the limit.
    always_comb begin
        if (any_edge) begin
            quiet_d = '0;
        end else if (quiet_q == SAT) begin
            quiet_d = quiet_q;
        end else begin
            quiet_d = quiet_q + 1'b1;
        end
    end

    // Hold the count and set the loss flag once the count passes the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quiet_q <= '0;
            lost_q  <= 1'b0;
        end else begin
            quiet_q <= quiet_d;
            lost_q  <= (quiet_d > LIM);
        end
    end

    // Apply the interrupt mask.
    always_comb begin
        irq = lost_q & ~mask;
    end
endmodule

// File: rtl/tx_line_encoder.sv
// Top level: synchronizer and strobe, single-rail coder, dual-rail bypass,
// output register and clock watchdog.
// Assumes: the configuration is static between resets, and clk is fast enough
// that each transmit-clock phase lasts at least two clk cycles.
module tx_line_encoder #(
    parameter int PIPE_DEPTH  = 8,
    parameter int LOS_LIMIT   = 70,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tclk_in,
    input  logic tx_data,
    input  logic tx_neg,
    input  logic cfg_t1,
    input  logic cfg_dual,
    input  logic cfg_zsub,
    input  logic cfg_fall_edge,
    input  logic cfg_invert,
    input  logic cfg_los_mask,
    output logic line_pos,
    output logic line_neg,
    output logic los_irq
);
    logic sym_stb;
    logic clk_edge;
    logic rail_p;
    logic rail_n;
    logic enc_pos;
    logic enc_neg;

    tle_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .tclk_in  (tclk_in),
        .din_a    (tx_data),
        .din_b    (tx_neg),
        .fall_sel (cfg_fall_edge),
        .invert   (cfg_invert),
        .sym_stb  (sym_stb),
        .any_edge (clk_edge),
        .rail_a   (rail_p),
        .rail_b   (rail_n)
    );

    tle_zs_encoder #(.DEPTH(PIPE_DEPTH)) u_enc (
        .clk     (clk),
        .rst_n   (rst_n),
        .stb     (sym_stb & ~cfg_dual),
        .bit_in  (rail_p),
        .std_t1  (cfg_t1),
        .zsub_en (cfg_zsub),
        .mk_pos  (enc_pos),
        .mk_neg  (enc_neg)
    );

    tle_clk_watch #(.LIMIT(LOS_LIMIT)) u_watch (
        .clk      (clk),
        .rst_n    (rst_n),
        .any_edge (clk_edge),
        .mask     (cfg_los_mask),
        .irq      (los_irq)
    );

    // Output register: the rail map in dual-rail mode, otherwise the coder's tail.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_pos <= 1'b0;
            line_neg <= 1'b0;
        end else if (sym_stb) begin
            if (cfg_dual) begin
                line_pos <= rail_n & ~rail_p;
                line_neg <= rail_p & ~rail_n;
            end else begin
                line_pos <= enc_pos;
                line_neg <= enc_neg;
            end
        end
    end
endmodule

// File: rtl/tx_line_encoder_chk.sv
// Property checker for tx_line_encoder, attached by bind.
// Assumes: the configuration is static between resets.
module tx_line_encoder_chk #(
    parameter int LOS_LIMIT = 70
) (
    input logic clk,
    input logic rst_n,
    input logic cfg_dual,
    input logic cfg_zsub,
    input logic cfg_los_mask,
    input logic sym_stb,
    input logic clk_edge,
    input logic rail_p,
    input logic rail_n,
    input logic line_pos,
    input logic line_neg,
    input logic los_irq
);
    localparam int QW = $clog2(LOS_LIMIT + 4);
    localparam logic [QW-1:0] QSAT = QW'(LOS_LIMIT + 3);

    logic [QW-1:0] quiet_q;
    logic          stb_d;
    logic          seen_q;
    logic          last_pos_q;

    // Independent count of quiet cycles and tracking of the last mark seen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quiet_q    <= '0;
            stb_d      <= 1'b0;
            seen_q     <= 1'b0;
            last_pos_q <= 1'b0;
        end else begin
            quiet_q <= clk_edge ? '0 : ((quiet_q == QSAT) ? quiet_q : quiet_q + 1'b1);
            stb_d   <= sym_stb;
            if (stb_d && (line_pos || line_neg)) begin
                seen_q     <= 1'b1;
                last_pos_q <= line_pos;
            end
        end
    end

    AST_RAIL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(line_pos && line_neg)); // R8

    AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
        !sym_stb |=> ($stable(line_pos) && $stable(line_neg))); // R6

    AST_DUAL_MAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_dual && sym_stb) |=>
            (line_pos == $past(rail_n && !rail_p)) && (line_neg == $past(rail_p && !rail_n))); // R5

    AST_AMI_ALT: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_dual && !cfg_zsub && stb_d && seen_q && (line_pos || line_neg))
            |-> (line_pos != last_pos_q)); // R1

    AST_IRQ_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_los_mask |-> !los_irq); // R9

    AST_LOS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clk_edge |=> !los_irq); // R9

    AST_LOS_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet_q < QW'(LOS_LIMIT)) |-> !los_irq); // R9

    AST_LOS_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        ((quiet_q >= QW'(LOS_LIMIT + 2)) && !cfg_los_mask) |-> los_irq); // R9

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!line_pos && !line_neg && !los_irq)); // R10
endmodule

bind tx_line_encoder tx_line_encoder_chk #(.LOS_LIMIT(LOS_LIMIT)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_dual     (cfg_dual),
    .cfg_zsub     (cfg_zsub),
    .cfg_los_mask (cfg_los_mask),
    .sym_stb      (sym_stb),
    .clk_edge     (clk_edge),
    .rail_p       (rail_p),
    .rail_n       (rail_n),
    .line_pos     (line_pos),
    .line_neg     (line_neg),
    .los_irq      (los_irq)
);

// File: tb/tx_line_encoder_test.sv
// Bench for tx_line_encoder: seeded random and directed bit streams, with
// expected line symbols built by a whole-array reference model.
module tx_line_encoder_test;
    localparam int N     = 64;
    localparam int DEPTH = 8;
    localparam int HALF  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tclk_in = 1'b0;
    logic tx_data = 1'b0;
    logic tx_neg = 1'b0;
    logic cfg_t1 = 1'b0;
    logic cfg_dual = 1'b0;
    logic cfg_zsub = 1'b0;
    logic cfg_fall_edge = 1'b0;
    logic cfg_invert = 1'b0;
    logic cfg_los_mask = 1'b0;
    logic line_pos;
    logic line_neg;
    logic los_irq;

    int checks = 0;
    int failures = 0;

    bit       bits  [N];
    bit       nbits [N];
    int       typ   [N];
    bit [1:0] exp_s [N];

    tx_line_encoder uut (
        .clk(clk), .rst_n(rst_n), .tclk_in(tclk_in), .tx_data(tx_data), .tx_neg(tx_neg),
        .cfg_t1(cfg_t1), .cfg_dual(cfg_dual), .cfg_zsub(cfg_zsub),
        .cfg_fall_edge(cfg_fall_edge), .cfg_invert(cfg_invert), .cfg_los_mask(cfg_los_mask),
        .line_pos(line_pos), .line_neg(line_neg), .los_irq(los_irq)
    );

    always #5 clk = ~clk;

    task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n   = 1'b0;
        tclk_in = cfg_fall_edge;
        repeat (3) @(negedge clk);
        check("R10 reset outputs", {line_pos, line_neg}, 2'b00);
        check("R10 reset irq", {1'b0, los_irq}, 2'b00);
        rst_n = 1'b1;
    endtask

    // One bit period: data set with the clock at its idle level, then the active edge.
    task automatic send_bit(input bit p, input bit n);
        tx_data = p ^ cfg_invert;
        tx_neg  = n ^ cfg_invert;
        tclk_in = cfg_fall_edge;
        repeat (HALF) @(negedge clk);
        tclk_in = ~cfg_fall_edge;
        repeat (HALF) @(negedge clk);
    endtask

    // Reference model: role tags for the whole stream first, then polarity.
    task automatic build_expected(input bit t1, input bit zsub);
        int  run = 0;
        bit  par = 1'b0;
        bit  last = 1'b0;
        bit  pol;
        for (int j = 0; j < N; j++) begin
            if (bits[j]) begin
                typ[j] = 1; run = 0; par = ~par;
            end else begin
                typ[j] = 0; run++;
                if (zsub && !t1 && run == 4) begin          // R2
                    if (!par) typ[j-3] = 1;
                    typ[j] = 2; run = 0; par = 1'b0;
                end else if (zsub && t1 && run == 8) begin  // R3
                    typ[j-4] = 2; typ[j-3] = 1; typ[j-1] = 2; typ[j] = 1; run = 0;
                end
            end
        end
        for (int j = 0; j < N; j++) begin
            if (typ[j] == 0) begin
                exp_s[j] = 2'b00;
            end else begin
                pol = (typ[j] == 2) ? last : ~last;
                last = pol;
                exp_s[j] = pol ? 2'b10 : 2'b01;
            end
        end
    endtask

    // pattern: 0 random with a bias toward zero, 1 all zeros, 2 all ones.
    task automatic run_coded(input string tag, input bit t1, input bit zsub,
                             input bit fall, input bit inv, input int pattern);
        cfg_dual = 1'b0; cfg_t1 = t1; cfg_zsub = zsub;
        cfg_fall_edge = fall; cfg_invert = inv;
        do_reset();
        for (int j = 0; j < N; j++) begin
            bits[j] = (pattern == 1) ? 1'b0 : (pattern == 2) ? 1'b1
                    : ($urandom_range(0, 99) < 35);
        end
        build_expected(t1, zsub);
        for (int k = 0; k < N; k++) begin
            send_bit(bits[k], 1'b0);
            if (k < DEPTH) check({tag, " R4 leading space"}, {line_pos, line_neg}, 2'b00);
            else           check(tag, {line_pos, line_neg}, exp_s[k-DEPTH]);
        end
    endtask

    // Dual rail: each rail pair maps straight to a symbol at its own strobe.
    task automatic run_dual(input bit t1, input bit zsub, input bit fall, input bit inv);
        cfg_dual = 1'b1; cfg_t1 = t1; cfg_zsub = zsub;
        cfg_fall_edge = fall; cfg_invert = inv;
        do_reset();
        for (int k = 0; k < N; k++) begin
            bits[k]  = $urandom_range(0, 1);
            nbits[k] = (k < 4) ? bits[k] : $urandom_range(0, 1);
            send_bit(bits[k], nbits[k]);
            check(inv ? "R5 R7 dual inverted" : "R5 dual map", {line_pos, line_neg},
                  {nbits[k] & ~bits[k], bits[k] & ~nbits[k]});
        end
    endtask

    initial begin
        void'($urandom(32'h1d2e_3f40));
        cfg_los_mask = 1'b0;
        run_coded("R1 AMI E1 rising",          1'b0, 1'b0, 1'b0, 1'b0, 0);
        run_coded("R1 AMI all ones",           1'b1, 1'b0, 1'b0, 1'b0, 2);
        run_coded("R1 R7 AMI inverted",        1'b1, 1'b0, 1'b0, 1'b1, 0);
        run_coded("R2 HDB3 random",            1'b0, 1'b1, 1'b0, 1'b0, 0);
        run_coded("R2 R6 HDB3 falling",        1'b0, 1'b1, 1'b1, 1'b0, 0);
        run_coded("R2 HDB3 all zeros",         1'b0, 1'b1, 1'b0, 1'b0, 1);
        run_coded("R3 B8ZS random",            1'b1, 1'b1, 1'b0, 1'b0, 0);
        run_coded("R3 B8ZS all zeros",         1'b1, 1'b1, 1'b0, 1'b0, 1);
        run_coded("R3 R6 R7 B8ZS falling inv", 1'b1, 1'b1, 1'b1, 1'b1, 0);
        run_coded("R1 AMI zeros no subst",     1'b0, 1'b0, 1'b0, 1'b0, 1);
        run_dual(1'b0, 1'b0, 1'b0, 1'b0);
        run_dual(1'b1, 1'b1, 1'b1, 1'b1);

        // Loss of clock: quiet windows below and above the limit.
        cfg_dual = 1'b0; cfg_fall_edge = 1'b0; cfg_invert = 1'b0;
        do_reset();
        send_bit(1'b0, 1'b0);
        repeat (50) @(negedge clk);
        check("R9 no loss below limit", {1'b0, los_irq}, 2'b00);
        repeat (40) @(negedge clk);
        check("R9 loss raised", {1'b0, los_irq}, 2'b01);
        cfg_los_mask = 1'b1;
        #1;
        check("R9 loss masked", {1'b0, los_irq}, 2'b00);
        cfg_los_mask = 1'b0;
        #1;
        check("R9 loss unmasked", {1'b0, los_irq}, 2'b01);
        send_bit(1'b0, 1'b0);
        check("R9 loss cleared by edge", {1'b0, los_irq}, 2'b00);
        for (int i = 0; i < 20; i++) begin
            send_bit(1'b1, 1'b0);
            check("R9 running clock no loss", {1'b0, los_irq}, 2'b00);
        end
        finish_run();
    end
endmodule